// File: doc/BRIEF.md
# Dual-Issue Pairing and Hazard Checker

This block sits at the end of an in-order, two-wide instruction front end. Each cycle it looks at the next two instructions in program order. The older one is candidate A and the younger one is candidate B. Each candidate carries a 4-bit class code and an operand-size flag. The block decides whether neither, only A, or both A and B issue in that cycle. Decoding, register dependence checks and the datapaths are handled elsewhere. The block knows only the issue-slot pairing rules, which execution unit of the second pipe a candidate would claim, and whether the two long-running iterative units are free.

The first pipe has one unit. It does integer add/subtract and address generation. The second pipe offers six mutually exclusive units: integer add/subtract, branch, integer multiply/divide, floating-point add, floating-point multiply and floating-point divide/square-root. Two down-counters model the iterative integer unit and the iterative floating-point unit. An issued multiply, divide or square-root operation loads its unit's counter with its occupancy time. A later candidate that needs the same unit waits until that counter has drained. The grants, the stall flag and the per-slot result latency are all combinational functions of the inputs and the counter state.

Class codes: 0 simple integer, 1 load, 2 store, 3 integer multiply, 4 integer divide, 5 branch/jump/call, 6 FP add/compare/convert, 7 FP multiply, 8 FP divide or square root, 9 FP reciprocal square root, 10 move to HI/LO, 11 move from HI/LO, 12 coprocessor register move, 13–15 issue-alone (unknown, multi-op, atomic). The size flag selects the 64-bit or double-precision variant.

Top module: `dual_issue_gate`

## Requirements
- R1: While `rst` is high both grants are 0. On the first cycle after `rst` falls, both busy flags read 0 and an iterative candidate issues without waiting.
- R2: With both counters idle, a valid A is always granted. B is granted only if A is granted, A's class is 0, 1 or 2, and B's class is one of 0, 3–12. At most one second-pipe unit is claimed per cycle.
- R3: Issue is in order. B is never granted in a cycle where A is not granted, even if B is free of hazards.
- R4: A candidate of class 13, 14 or 15 issues only in slot A, and nothing issues beside it.
- R5: When A is a branch (class 5), B is not granted in that cycle.
- R6: Integer multiply keeps the integer iterative unit busy for 3 cycles (32-bit) or 8 cycles (64-bit). Integer divide keeps it busy for 36 or 68 cycles. A later class 3 or 4 candidate issued at cycle t is granted no earlier than cycle t+N.
- R7: On the floating-point iterative unit, multiply occupies 1 or 2 cycles, divide/square-root 21 or 36, and reciprocal square root 38 or 68 (single or double). A later class 7, 8 or 9 candidate is granted no earlier than t+N.
- R8: The two counters are independent. A candidate that needs neither unit issues even while both are busy.
- R9: A granted slot reports its latency: 1 for classes 0, 2, 11 and 13–15; 2 for 1 and 12; 3 for 5 and 10; 4 for 6; 5/9 for 3; 36/68 for 4; 4/5 for 7; 21/36 for 8; 38/68 for 9. The second value applies when the size flag is set. A slot that is not granted reports 0.
- R10: `stall` is high exactly when a valid candidate is not granted.
- R11: `int_busy` and `fp_busy` are high while cycles of the respective unit's occupancy window remain after the issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Older candidate present |
| a_class | input | 4 | Older candidate class code |
| a_wide | input | 1 | Older candidate 64-bit / double flag |
| b_valid | input | 1 | Younger candidate present |
| b_class | input | 4 | Younger candidate class code |
| b_wide | input | 1 | Younger candidate 64-bit / double flag |
| a_grant | output | 1 | Older candidate issues this cycle |
| b_grant | output | 1 | Younger candidate issues this cycle |
| stall | output | 1 | A valid candidate is held |
| a_latency | output | 7 | Result latency of the older candidate if granted |
| b_latency | output | 7 | Result latency of the younger candidate if granted |
| int_busy | output | 1 | Integer iterative unit occupied |
| fp_busy | output | 1 | Floating-point iterative unit occupied |

## Verification
The bench builds the block with its default occupancy and latency parameters. The longest window is therefore 68 cycles, and each one can be walked cycle by cycle in full. Class codes are only 4 bits wide, so every ordered class pair, every size-flag combination and every valid pattern is swept with idle counters. Each occupancy window is then measured by probing with a same-unit candidate every cycle until it issues. The same approach is used to check cross-unit independence and the clearing effect of reset.

// File: rtl/dia_pkg.sv
`timescale 1ns/1ps
package dia_pkg;

    typedef enum logic [3:0] {
        CL_IALU   = 4'd0,
        CL_LOAD   = 4'd1,
        CL_STORE  = 4'd2,
        CL_IMUL   = 4'd3,
        CL_IDIV   = 4'd4,
        CL_BRANCH = 4'd5,
        CL_FADD   = 4'd6,
        CL_FMUL   = 4'd7,
        CL_FDIV   = 4'd8,
        CL_FRSQ   = 4'd9,
        CL_TOHL   = 4'd10,
        CL_FROMHL = 4'd11,
        CL_XFER   = 4'd12,
        CL_ALONE0 = 4'd13,
        CL_ALONE1 = 4'd14,
        CL_ALONE2 = 4'd15
    } iclass_e;

    // Second-pipe unit index, one bit each in a claim vector
    localparam int UNIT_N   = 6;
    localparam int U_ADD    = 0;
    localparam int U_BRANCH = 1;
    localparam int U_MULDIV = 2;
    localparam int U_FADD   = 3;
    localparam int U_FMUL   = 4;
    localparam int U_FDIV   = 5;

    function automatic logic fits_front(input iclass_e c);
        return (c == CL_IALU) || (c == CL_LOAD) || (c == CL_STORE);
    endfunction

    function automatic logic issues_alone(input iclass_e c);
        return (c == CL_ALONE0) || (c == CL_ALONE1) || (c == CL_ALONE2);
    endfunction

    function automatic logic fits_back(input iclass_e c);
        return !issues_alone(c) && (c != CL_LOAD) && (c != CL_STORE);
    endfunction

    function automatic logic needs_int_iter(input iclass_e c);
        return (c == CL_IMUL) || (c == CL_IDIV);
    endfunction

    function automatic logic needs_fp_iter(input iclass_e c);
        return (c == CL_FMUL) || (c == CL_FDIV) || (c == CL_FRSQ);
    endfunction

    function automatic logic [UNIT_N-1:0] back_unit(input iclass_e c);
        logic [UNIT_N-1:0] u;
        u = '0;
        case (c)
            CL_IALU, CL_XFER:                    u[U_ADD]    = 1'b1;
            CL_BRANCH:                           u[U_BRANCH] = 1'b1;
            CL_IMUL, CL_IDIV, CL_TOHL, CL_FROMHL: u[U_MULDIV] = 1'b1;
            CL_FADD:                             u[U_FADD]   = 1'b1;
            CL_FMUL:                             u[U_FMUL]   = 1'b1;
            CL_FDIV, CL_FRSQ:                    u[U_FDIV]   = 1'b1;
            default:                             u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/dia_busy_ctr.sv
`timescale 1ns/1ps
module dia_busy_ctr #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);

    // R6
    drain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt != '0 && !load) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R6
    load_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (st_q.cnt == '0));

endmodule

// File: rtl/dia_pair_rules.sv
`timescale 1ns/1ps
module dia_pair_rules
    import dia_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    a_valid,
    input  iclass_e a_cls,
    input  logic    b_valid,
    input  iclass_e b_cls,
    input  logic    int_busy,
    input  logic    fp_busy,
    output logic    a_grant,
    output logic    b_grant,
    output logic    int_start,
    output logic    fp_start,
    output logic    start_from_b
);

    logic               a_free, b_free, b_pairs;
    logic [UNIT_N-1:0]  claim;

    always_comb begin
        a_free  = !(needs_int_iter(a_cls) && int_busy) &&
                  !(needs_fp_iter(a_cls) && fp_busy);
        b_free  = !(needs_int_iter(b_cls) && int_busy) &&
                  !(needs_fp_iter(b_cls) && fp_busy);
        b_pairs = fits_front(a_cls) && fits_back(b_cls);

        a_grant = !rst && a_valid && a_free;
        b_grant = a_grant && b_valid && b_free && b_pairs;

        // only one candidate per cycle ever lands on the second pipe
        if (b_grant) begin
            claim = back_unit(b_cls);
        end else if (a_grant && !fits_front(a_cls)) begin
            claim = back_unit(a_cls);
        end else begin
            claim = '0;
        end

        start_from_b = b_grant && (needs_int_iter(b_cls) || needs_fp_iter(b_cls));
        int_start    = (a_grant && needs_int_iter(a_cls)) ||
                       (b_grant && needs_int_iter(b_cls));
        fp_start     = (a_grant && needs_fp_iter(a_cls)) ||
                       (b_grant && needs_fp_iter(b_cls));
    end

    // R2
    unit_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim));

    // R3
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        b_grant |-> a_grant);

    // R4
    alone_chk: assert property (@(posedge clk) disable iff (rst)
        (a_grant && issues_alone(a_cls)) |-> !b_grant);

    // R5
    branch_last_chk: assert property (@(posedge clk) disable iff (rst)
        (a_grant && a_cls == CL_BRANCH) |-> !b_grant);

    // R6
    single_iter_start_chk: assert property (@(posedge clk) disable iff (rst)
        !(int_start && fp_start));

endmodule

// File: rtl/dia_latency.sv
`timescale 1ns/1ps
module dia_latency
    import dia_pkg::*;
#(
    parameter int LAT_W      = 7,
    parameter int IMUL_LAT_N = 5,
    parameter int IMUL_LAT_W = 9,
    parameter int IDIV_LAT_N = 36,
    parameter int IDIV_LAT_W = 68,
    parameter int FMUL_LAT_S = 4,
    parameter int FMUL_LAT_D = 5,
    parameter int FDIV_LAT_S = 21,
    parameter int FDIV_LAT_D = 36,
    parameter int FRSQ_LAT_S = 38,
    parameter int FRSQ_LAT_D = 68
) (
    input  iclass_e          cls,
    input  logic             wide,
    input  logic             issued,
    output logic [LAT_W-1:0] lat
);

    int cyc;

    always_comb begin
        case (cls)
            CL_IALU, CL_STORE, CL_FROMHL: cyc = 1;
            CL_LOAD, CL_XFER:             cyc = 2;
            CL_BRANCH, CL_TOHL:           cyc = 3;
            CL_FADD:                      cyc = 4;
            CL_IMUL:                      cyc = wide ? IMUL_LAT_W : IMUL_LAT_N;
            CL_IDIV:                      cyc = wide ? IDIV_LAT_W : IDIV_LAT_N;
            CL_FMUL:                      cyc = wide ? FMUL_LAT_D : FMUL_LAT_S;
            CL_FDIV:                      cyc = wide ? FDIV_LAT_D : FDIV_LAT_S;
            CL_FRSQ:                      cyc = wide ? FRSQ_LAT_D : FRSQ_LAT_S;
            default:                      cyc = 1;
        endcase
        lat = issued ? LAT_W'(cyc) : '0;
    end

endmodule

// File: rtl/dual_issue_gate.sv
`timescale 1ns/1ps
module dual_issue_gate
    import dia_pkg::*;
#(
    parameter int IMUL_CYC_N = 3,
    parameter int IMUL_CYC_W = 8,
    parameter int IDIV_CYC_N = 36,
    parameter int IDIV_CYC_W = 68,
    parameter int FMUL_CYC_S = 1,
    parameter int FMUL_CYC_D = 2,
    parameter int FDIV_CYC_S = 21,
    parameter int FDIV_CYC_D = 36,
    parameter int FRSQ_CYC_S = 38,
    parameter int FRSQ_CYC_D = 68,
    parameter int IMUL_LAT_N = 5,
    parameter int IMUL_LAT_W = 9,
    parameter int FMUL_LAT_S = 4,
    parameter int FMUL_LAT_D = 5,
    parameter int LAT_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_valid,
    input  logic [3:0]       a_class,
    input  logic             a_wide,
    input  logic             b_valid,
    input  logic [3:0]       b_class,
    input  logic             b_wide,
    output logic             a_grant,
    output logic             b_grant,
    output logic             stall,
    output logic [LAT_W-1:0] a_latency,
    output logic [LAT_W-1:0] b_latency,
    output logic             int_busy,
    output logic             fp_busy
);

    localparam int INT_MAX_A = (IMUL_CYC_N > IMUL_CYC_W) ? IMUL_CYC_N : IMUL_CYC_W;
    localparam int INT_MAX_B = (IDIV_CYC_N > IDIV_CYC_W) ? IDIV_CYC_N : IDIV_CYC_W;
    localparam int INT_MAX   = (INT_MAX_A > INT_MAX_B) ? INT_MAX_A : INT_MAX_B;
    localparam int FP_MAX_A  = (FMUL_CYC_S > FMUL_CYC_D) ? FMUL_CYC_S : FMUL_CYC_D;
    localparam int FP_MAX_B  = (FDIV_CYC_S > FDIV_CYC_D) ? FDIV_CYC_S : FDIV_CYC_D;
    localparam int FP_MAX_C  = (FRSQ_CYC_S > FRSQ_CYC_D) ? FRSQ_CYC_S : FRSQ_CYC_D;
    localparam int FP_MAX_AB = (FP_MAX_A > FP_MAX_B) ? FP_MAX_A : FP_MAX_B;
    localparam int FP_MAX    = (FP_MAX_AB > FP_MAX_C) ? FP_MAX_AB : FP_MAX_C;
    localparam int INT_CW    = $clog2(INT_MAX + 1);
    localparam int FP_CW     = $clog2(FP_MAX + 1);
    localparam int SLOTS     = 2;

    iclass_e           cls   [SLOTS];
    logic              wide  [SLOTS];
    logic              grant [SLOTS];
    logic [LAT_W-1:0]  lat   [SLOTS];

    logic              int_start, fp_start, start_from_b;
    iclass_e           start_cls;
    logic              start_wide;
    int                int_occ, fp_occ;
    logic [INT_CW-1:0] int_load_val;
    logic [FP_CW-1:0]  fp_load_val;

    assign cls[0]  = iclass_e'(a_class);
    assign cls[1]  = iclass_e'(b_class);
    assign wide[0] = a_wide;
    assign wide[1] = b_wide;

    dia_pair_rules u_rules (
        .clk          (clk),
        .rst          (rst),
        .a_valid      (a_valid),
        .a_cls        (cls[0]),
        .b_valid      (b_valid),
        .b_cls        (cls[1]),
        .int_busy     (int_busy),
        .fp_busy      (fp_busy),
        .a_grant      (grant[0]),
        .b_grant      (grant[1]),
        .int_start    (int_start),
        .fp_start     (fp_start),
        .start_from_b (start_from_b)
    );

    // occupancy of the one iterative instruction that may start this cycle
    always_comb begin
        start_cls  = start_from_b ? cls[1]  : cls[0];
        start_wide = start_from_b ? wide[1] : wide[0];
        case (start_cls)
            CL_IMUL: int_occ = start_wide ? IMUL_CYC_W : IMUL_CYC_N;
            CL_IDIV: int_occ = start_wide ? IDIV_CYC_W : IDIV_CYC_N;
            default: int_occ = 1;
        endcase
        case (start_cls)
            CL_FMUL: fp_occ = start_wide ? FMUL_CYC_D : FMUL_CYC_S;
            CL_FDIV: fp_occ = start_wide ? FDIV_CYC_D : FDIV_CYC_S;
            CL_FRSQ: fp_occ = start_wide ? FRSQ_CYC_D : FRSQ_CYC_S;
            default: fp_occ = 1;
        endcase
        int_load_val = INT_CW'(int_occ - 1);
        fp_load_val  = FP_CW'(fp_occ - 1);
    end

    dia_busy_ctr #(.CW(INT_CW)) u_int_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (int_start),
        .load_val (int_load_val),
        .busy     (int_busy)
    );

    dia_busy_ctr #(.CW(FP_CW)) u_fp_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (fp_start),
        .load_val (fp_load_val),
        .busy     (fp_busy)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_lat
        dia_latency #(
            .LAT_W      (LAT_W),
            .IMUL_LAT_N (IMUL_LAT_N),
            .IMUL_LAT_W (IMUL_LAT_W),
            .IDIV_LAT_N (IDIV_CYC_N),
            .IDIV_LAT_W (IDIV_CYC_W),
            .FMUL_LAT_S (FMUL_LAT_S),
            .FMUL_LAT_D (FMUL_LAT_D),
            .FDIV_LAT_S (FDIV_CYC_S),
            .FDIV_LAT_D (FDIV_CYC_D),
            .FRSQ_LAT_S (FRSQ_CYC_S),
            .FRSQ_LAT_D (FRSQ_CYC_D)
        ) u_lat (
            .cls    (cls[s]),
            .wide   (wide[s]),
            .issued (grant[s]),
            .lat    (lat[s])
        );
    end

    assign a_grant   = grant[0];
    assign b_grant   = grant[1];
    assign a_latency = lat[0];
    assign b_latency = lat[1];
    assign stall     = (a_valid && !grant[0]) || (b_valid && !grant[1]);

    // R1
    always_comb begin
        if (rst) begin
            reset_quiet_chk: assert (!a_grant && !b_grant);
        end
    end

    // R8
    busy_blocks_int_chk: assert property (@(posedge clk) disable iff (rst)
        (int_busy && a_valid && needs_int_iter(cls[0])) |-> !a_grant);

    // R8
    plain_not_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (a_valid && !needs_int_iter(cls[0]) && !needs_fp_iter(cls[0])) |-> a_grant);

endmodule

// File: tb/dual_issue_gate_tb_top.sv
`timescale 1ns/1ps
module dual_issue_gate_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_valid = 1'b0, b_valid = 1'b0;
    logic [3:0] a_class = '0, b_class = '0;
    logic       a_wide = 1'b0, b_wide = 1'b0;
    logic       a_grant, b_grant, stall, int_busy, fp_busy;
    logic [6:0] a_latency, b_latency;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_issue_gate dut_i (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_class(a_class), .a_wide(a_wide),
        .b_valid(b_valid), .b_class(b_class), .b_wide(b_wide),
        .a_grant(a_grant), .b_grant(b_grant), .stall(stall),
        .a_latency(a_latency), .b_latency(b_latency),
        .int_busy(int_busy), .fp_busy(fp_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input bit va, input int ca, input bit wa,
                         input bit vb, input int cb, input bit wb);
        a_valid = va; a_class = 4'(ca); a_wide = wa;
        b_valid = vb; b_class = 4'(cb); b_wide = wb;
    endtask

    task automatic do_reset();
        drive(0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    function automatic bit front_ok(input int c);
        return c <= 2;
    endfunction

    function automatic bit back_ok(input int c);
        return (c == 0) || (c >= 3 && c <= 12);
    endfunction

    function automatic int exp_lat(input int c, input bit w);
        case (c)
            0, 2, 11: return 1;
            1, 12:    return 2;
            5, 10:    return 3;
            6:        return 4;
            3:        return w ? 9 : 5;
            4:        return w ? 68 : 36;
            7:        return w ? 5 : 4;
            8:        return w ? 36 : 21;
            9:        return w ? 68 : 38;
            default:  return 1;
        endcase
    endfunction

    // issue an iterative op alone, then probe each cycle with a narrow op of the same unit
    task automatic measure(input string req, input int cls, input bit w,
                           input int probe, input int exp_n, input bit fp_unit);
        int k;
        do_reset();
        drive(1, cls, w, 0, 0, 0);
        #1;
        check(req, a_grant, 1);
        tick();
        drive(1, probe, 0, 0, 0, 0);
        #1;
        // R11
        check("R11", fp_unit ? fp_busy : int_busy, exp_n > 1);
        k = 1;
        while (!a_grant && k < 200) begin
            tick();
            k++;
            #1;
        end
        check(req, k, exp_n);
        check("R11", fp_unit ? fp_busy : int_busy, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: grants stay low while reset is held
        drive(1, 3, 0, 1, 0, 0);
        tick();
        #1;
        check("R1", {a_grant, b_grant}, 0);
        rst = 1'b0;
        #1;
        check("R1", int_busy | fp_busy, 0);
        check("R1", a_grant, 1);
        do_reset();

        // R2 R3 R4 R5 R9 R10: full sweep with idle counters
        for (int va = 0; va < 2; va++)
        for (int vb = 0; vb < 2; vb++)
        for (int ca = 0; ca < 16; ca++)
        for (int cb = 0; cb < 16; cb++)
        for (int wa = 0; wa < 2; wa++)
        for (int wb = 0; wb < 2; wb++) begin
            bit eg0, eg1, est;
            string tag;
            rst = 1'b0;
            drive(va[0], ca, wa[0], vb[0], cb, wb[0]);
            #1;
            eg0 = va[0];
            eg1 = va[0] && vb[0] && front_ok(ca) && back_ok(cb);
            est = (va[0] && !eg0) || (vb[0] && !eg1);
            tag = (ca >= 13) ? "R4" : (ca == 5) ? "R5" : (!va[0] && vb[0]) ? "R3" : "R2";
            check(tag, {a_grant, b_grant}, {eg0, eg1});
            check("R9", {a_latency, b_latency},
                  {7'(eg0 ? exp_lat(ca, wa[0]) : 0), 7'(eg1 ? exp_lat(cb, wb[0]) : 0)});
            check("R10", stall, est);
            drive(0, 0, 0, 0, 0, 0);
            rst = 1'b1;
            tick();
        end
        rst = 1'b0;

        // R6: integer iterative windows
        measure("R6", 3, 0, 3, 3, 0);
        measure("R6", 3, 1, 3, 8, 0);
        measure("R6", 4, 0, 3, 36, 0);
        measure("R6", 4, 1, 3, 68, 0);
        // R7: floating-point iterative windows
        measure("R7", 7, 0, 7, 1, 1);
        measure("R7", 7, 1, 7, 2, 1);
        measure("R7", 8, 0, 7, 21, 1);
        measure("R7", 8, 1, 7, 36, 1);
        measure("R7", 9, 0, 7, 38, 1);
        measure("R7", 9, 1, 7, 68, 1);

        // R8: independence of the two units, plain ops unaffected
        do_reset();
        drive(1, 4, 1, 0, 0, 0);
        tick();
        drive(1, 8, 0, 0, 0, 0);
        #1;
        check("R8", a_grant, 1);
        tick();
        check("R8", {int_busy, fp_busy}, 2'b11);
        drive(1, 3, 0, 0, 0, 0);
        #1;
        check("R8", {a_grant, stall}, 2'b01);
        drive(1, 1, 0, 1, 6, 1);
        #1;
        check("R8", {a_grant, b_grant, stall}, 3'b110);
        // R3: younger held behind a stalled older even if hazard free
        drive(1, 4, 0, 1, 0, 0);
        #1;
        check("R3", {a_grant, b_grant, stall}, 3'b001);
        // younger iterative blocked while older plain op issues
        drive(1, 0, 0, 1, 3, 0);
        #1;
        check("R8", {a_grant, b_grant, b_latency}, {2'b10, 7'd0});

        // R1: reset clears a running window
        drive(0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        drive(1, 3, 0, 0, 0, 0);
        #1;
        check("R1", {int_busy, fp_busy, a_grant}, 3'b001);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule